// File: doc/BRIEF.md
# 100BASE-TX 4B5B Transmit Symbol Encoder

This block sits between the MII transmit side of a MAC and the scrambler of a 100BASE-TX transmitter. On every 25 MHz transmit clock it samples one nibble with its enable and error qualifiers and produces one 5-bit code group. Each frame opens with the J/K start delimiter, which replaces the first two preamble nibbles. The remaining preamble and data nibbles are mapped through the 4B5B data table. The T/R end delimiter follows the last nibble, and IDLE is sent between frames. A transmit error inside a frame turns that nibble into HALT.

A bypass input disables all framing and coding. The error line then acts as the fifth bit of a raw symbol, and the symbol is passed straight through. This serves repeater-style use, where the symbols are already built upstream. The output is registered: the code group for the inputs sampled at a clock edge appears just after that edge.

Top module: `tx4b5b_enc`

## Requirements
- R1: While rst_n is low, code holds IDLE (11111) and the framer is in its between-frames state.
- R2: With bypass low, the first edge in the between-frames state that samples tx_en high emits J (11000), and the next edge emits K (10001). The nibbles and tx_er sampled at those two edges are discarded.
- R3: Every later nibble sampled with tx_en high and tx_er low is emitted as its data code group, indexed by txd value 0 to F: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: The first edge after K that samples tx_en low emits T (01101), and the following edge emits R (00111).
- R5: After R, IDLE is emitted on every edge that samples tx_en low. The inputs sampled at the T and R edges are ignored. A tx_en still high after R starts a new frame with J.
- R6: A nibble sampled past the delimiter with tx_en and tx_er both high is emitted as HALT (00100).
- R7: A frame whose tx_en is high for only one or two edges still emits the full sequence J, K, T, R.
- R8: With bypass high, code becomes {tx_er, txd} when tx_en is sampled high and IDLE otherwise. No delimiters are inserted, and the framer returns to the between-frames state. Any frame in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Nibble valid / frame enable |
| tx_er | input | 1 | Coding error request; fifth raw bit in bypass |
| txd | input | NIB_W | Transmit nibble |
| bypass | input | 1 | Raw-symbol pass-through select |
| code | output | NIB_W+1 | Registered 5-bit code group |

## Verification
On every cycle, the assertions check the following:
- J is always followed by K, and T is always followed by R.
- R is followed by IDLE or a new J.
- An erroneous in-frame nibble becomes HALT.
- In bypass, the raw symbol appears one edge after it is sampled.

Only the bench's scenarios can show some other behaviours, because they depend on the whole input history. These are:
- the full data table mapping;
- the discarding of the two preamble nibbles and of the nibbles sampled at the T and R edges;
- short frames of one and two nibbles;
- back-to-back frames;
- a frame aborted by entering bypass, and a frame started on leaving it.

// File: rtl/tx4b5b_pkg.sv
package tx4b5b_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = NIB_W + 1;

  localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_HALT = 5'b00100;

  typedef enum logic [2:0] {
    FS_GAP  = 3'd0,
    FS_K    = 3'd1,
    FS_BODY = 3'd2,
    FS_T    = 3'd3,
    FS_R    = 3'd4
  } frm_st_e;
endpackage

// File: rtl/tx4b5b_datamap.sv
module tx4b5b_datamap
  import tx4b5b_pkg::*;
#(
  parameter int NW = NIB_W,
  localparam int SW = NW + 1
) (
  input  logic [NW-1:0] nib,
  output logic [SW-1:0] sym
);
  always_comb begin
    case (nib)
      4'h0: sym = 5'b11110;
      4'h1: sym = 5'b01001;
      4'h2: sym = 5'b10100;
      4'h3: sym = 5'b10101;
      4'h4: sym = 5'b01010;
      4'h5: sym = 5'b01011;
      4'h6: sym = 5'b01110;
      4'h7: sym = 5'b01111;
      4'h8: sym = 5'b10010;
      4'h9: sym = 5'b10011;
      4'hA: sym = 5'b10110;
      4'hB: sym = 5'b10111;
      4'hC: sym = 5'b11010;
      4'hD: sym = 5'b11011;
      4'hE: sym = 5'b11100;
      default: sym = 5'b11101;
    endcase
  end
endmodule

// File: rtl/tx4b5b_framer.sv
module tx4b5b_framer
  import tx4b5b_pkg::*;
#(
  parameter int NW = NIB_W,
  localparam int SW = NW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          tx_er,
  input  logic          bypass,
  input  logic [NW-1:0] txd,
  input  logic [SW-1:0] data_sym,
  output logic [SW-1:0] sym_nxt,
  output frm_st_e       st_q
);
  frm_st_e st_d;

  always_comb begin
    st_d    = st_q;
    sym_nxt = SYM_IDLE;
    if (bypass) begin
      st_d    = FS_GAP;
      sym_nxt = tx_en ? {tx_er, txd} : SYM_IDLE;
    end else begin
      case (st_q)
        FS_GAP: begin
          if (tx_en) begin
            sym_nxt = SYM_J;
            st_d    = FS_K;
          end
        end
        FS_K: begin
          sym_nxt = SYM_K;
          st_d    = tx_en ? FS_BODY : FS_T;
        end
        FS_BODY: begin
          if (tx_en) begin
            sym_nxt = tx_er ? SYM_HALT : data_sym;
          end else begin
            sym_nxt = SYM_T;
            st_d    = FS_R;
          end
        end
        FS_T: begin
          sym_nxt = SYM_T;
          st_d    = FS_R;
        end
        FS_R: begin
          sym_nxt = SYM_R;
          st_d    = FS_GAP;
        end
        default: begin
          sym_nxt = SYM_IDLE;
          st_d    = FS_GAP;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_GAP;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/tx4b5b_enc.sv
module tx4b5b_enc
  import tx4b5b_pkg::*;
#(
  parameter int NIB_WIDTH = NIB_W,
  localparam int SYMW = NIB_WIDTH + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_en,
  input  logic                 tx_er,
  input  logic [NIB_WIDTH-1:0] txd,
  input  logic                 bypass,
  output logic [SYMW-1:0]      code
);
  logic [SYMW-1:0] data_sym;
  logic [SYMW-1:0] sym_nxt;
  logic [SYMW-1:0] code_q;
  frm_st_e         st_q;

  tx4b5b_datamap #(.NW(NIB_WIDTH)) u_map (
    .nib (txd),
    .sym (data_sym)
  );

  tx4b5b_framer #(.NW(NIB_WIDTH)) u_frm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .tx_er    (tx_er),
    .bypass   (bypass),
    .txd      (txd),
    .data_sym (data_sym),
    .sym_nxt  (sym_nxt),
    .st_q     (st_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= SYM_IDLE;
    else        code_q <= sym_nxt;
  end

  assign code = code_q;

  assert_j_then_k_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == SYM_J && !bypass && !$past(bypass)) |=> code_q == SYM_K);

  assert_t_then_r_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == SYM_T && !bypass && !$past(bypass)) |=> code_q == SYM_R);

  assert_r_then_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == SYM_R && !bypass && !$past(bypass))
      |=> (code_q == SYM_IDLE || code_q == SYM_J));

  assert_halt_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && st_q == FS_BODY && tx_en && tx_er) |=> code_q == SYM_HALT);

  assert_raw_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && tx_en) |=> code_q == $past({tx_er, txd}));
endmodule

// File: tb/sim_tx4b5b_enc.sv
module sim_tx4b5b_enc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       bypass = 1'b0;
  logic [4:0] code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit chk_on = 1'b0;

  always #2 clk = ~clk;

  tx4b5b_enc u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er),
    .txd(txd), .bypass(bypass), .code(code)
  );

  localparam logic [4:0] TAB [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
    5'b01010, 5'b01011, 5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110,
    5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};

  // behavioural reference: nibble position in frame plus queue of pending delimiters
  int         pos = -1;
  int         flen = 0;
  logic [4:0] pend[$];
  logic [4:0] exp_code = 5'b11111;
  string      exp_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      pos = -1; flen = 0; pend.delete(); exp_code = 5'b11111; exp_tag = "R1";
    end else if (bypass) begin
      pos = -1; pend.delete();
      exp_code = tx_en ? {tx_er, txd} : 5'b11111; exp_tag = "R8";
    end else if (pend.size() > 0) begin
      exp_code = pend.pop_front();
      exp_tag = (flen <= 2) ? "R7" : "R4";
    end else if (pos < 0) begin
      if (tx_en) begin exp_code = 5'b11000; pos = 1; flen = 1; exp_tag = "R2"; end
      else begin exp_code = 5'b11111; exp_tag = "R5"; end
    end else if (pos == 1) begin
      exp_code = 5'b10001; exp_tag = "R2";
      if (tx_en) begin pos = 2; flen = 2; end
      else begin pend.push_back(5'b01101); pend.push_back(5'b00111); pos = -1; end
    end else begin
      if (tx_en) begin
        flen++;
        if (tx_er) begin exp_code = 5'b00100; exp_tag = "R6"; end
        else begin exp_code = TAB[txd]; exp_tag = "R3"; end
      end else begin
        exp_code = 5'b01101; exp_tag = (flen <= 2) ? "R7" : "R4";
        pend.push_back(5'b00111); pos = -1;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      checks++;
      if (code !== exp_code) begin
        errors++;
        $display("FAIL %s code=%b expected=%b", exp_tag, code, exp_code);
      end
    end
  end

  task automatic cyc(input logic en, input logic er, input logic [3:0] d, input logic byp);
    @(negedge clk);
    tx_en = en; tx_er = er; txd = d; bypass = byp;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'h0, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (code !== 5'b11111) begin
      errors++;
      $display("FAIL R1 code=%b expected=%b", code, 5'b11111);
    end
    rst_n = 1'b1;
    chk_on = 1'b1;
    gap(3);
    // R2 R3: full frame, preamble then SFD then every nibble value
    for (int i = 0; i < 14; i++) cyc(1'b1, (i == 0), 4'h5, 1'b0);
    cyc(1'b1, 1'b0, 4'hD, 1'b0);
    for (int v = 0; v < 16; v++) cyc(1'b1, 1'b0, v[3:0], 1'b0);
    gap(4);
    // R7: one- and two-nibble frames
    cyc(1'b1, 1'b0, 4'h5, 1'b0);
    gap(5);
    cyc(1'b1, 1'b1, 4'h5, 1'b0);
    cyc(1'b1, 1'b0, 4'h5, 1'b0);
    gap(5);
    // R6: error inside data
    for (int i = 0; i < 6; i++) cyc(1'b1, (i == 3 || i == 4), 4'hA, 1'b0);
    gap(4);
    // R5: tx_en held across the T/R edges restarts with J
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 4'h3, 1'b0);
    cyc(1'b0, 1'b0, 4'h0, 1'b0);
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 4'h9, 1'b0);
    gap(5);
    // R8: raw symbols, including ones matching delimiters
    cyc(1'b1, 1'b1, 4'h8, 1'b1);
    cyc(1'b1, 1'b0, 4'hD, 1'b1);
    cyc(1'b0, 1'b1, 4'h7, 1'b1);
    cyc(1'b1, 1'b0, 4'h4, 1'b1);
    cyc(1'b1, 1'b1, 4'hF, 1'b1);
    gap(3);
    // R8: bypass aborts a frame, leaving bypass with tx_en high starts J
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 4'h6, 1'b0);
    cyc(1'b1, 1'b0, 4'h6, 1'b1);
    cyc(1'b1, 1'b0, 4'h2, 1'b1);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 4'hC, 1'b0);
    gap(6);
    chk_on = 1'b0;
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule